// File: doc/BRIEF.md
# Video Vertical Reference and Field Detector

This block sits behind a video input port. It takes two asynchronous reference lines, a vertical reference and a horizontal reference, and brings both into the block clock domain. From them it derives two results. The first is a single-cycle vertical pulse that marks the start of a field. The second is a registered field identifier, which is the level of the horizontal reference captured at a chosen edge of the vertical reference.

Four static configuration pins control the block. One picks which edge of the vertical reference counts as the vertical mark. One switches between gate mode and frame-sync mode. In gate mode the vertical reference is treated as a V-sync or V-gate and only the selected edge produces a pulse. In frame-sync mode both edges produce a pulse. One pin picks the edge at which the field identifier is captured, and one inverts the value that is captured. The block has no data stream, so every pin is a plain level with no handshake.

Top module: `vfd_top`

## Requirements
- R1: While `rst_n` is low and after its release, with both references held low, `vpulse` is 0 and `field_id` is 0.
- R2: With `cfg_fsync`=0 and `cfg_vfall`=0, a rising edge on `vref_in` gives `vpulse`=1 for exactly one cycle, 3 clock edges after the input change; a falling edge gives no pulse.
- R3: With `cfg_fsync`=0 and `cfg_vfall`=1, only a falling edge on `vref_in` gives the one-cycle pulse; a rising edge gives none.
- R4: With `cfg_fsync`=1, every rising and every falling edge on `vref_in` gives a one-cycle pulse, whatever the value of `cfg_vfall`.
- R5: With `cfg_fld_rise`=0, at each falling edge of `vref_in` the block loads `field_id` with the synchronized level of `href_in` (XOR `cfg_fld_inv`). The new value shows 3 clock edges after the input change.
- R6: With `cfg_fld_rise`=1, `field_id` is loaded at rising edges of `vref_in` instead, and falling edges leave it unchanged.
- R7: With `cfg_fld_inv`=1, the value loaded into `field_id` is the inverse of the sampled `href_in` level.
- R8: `field_id` changes only at a field-detection edge. Changes of `href_in` or of `cfg_fld_inv` between edges leave it unchanged.
- R9: A change of any configuration pin while `vref_in` is steady produces no pulse and no change of `field_id`. The new setting applies from the next edge.
- R10: When a vertical pulse and a field update come from the same edge, `field_id` already holds its new value in the cycle where `vpulse` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vref_in | input | 1 | Asynchronous vertical reference |
| href_in | input | 1 | Asynchronous horizontal reference |
| cfg_vfall | input | 1 | 0: rising edge is the vertical mark; 1: falling edge is the vertical mark |
| cfg_fsync | input | 1 | 0: gate mode (selected edge only); 1: frame-sync mode (both edges) |
| cfg_fld_rise | input | 1 | 0: field captured at falling edge; 1: captured at rising edge |
| cfg_fld_inv | input | 1 | 1: invert the captured field value |
| vpulse | output | 1 | One-cycle vertical reference pulse |
| field_id | output | 1 | Registered field identifier |

## Verification
An input change passes through two synchronizer flops and then one output register, so both `vpulse` and a new `field_id` are due 3 clock edges after the change. The bench drives inputs on falling clock edges and samples on the following falling edges. It expects the pulse on the third sample only, requires `vpulse`=0 on the samples before and after it, and checks `field_id` on that third sample. `href_in` is set at least three cycles ahead of the reference edge so that its synchronized value is settled when the edge is detected. During those waits the bench also confirms that `field_id` does not move.

// File: rtl/vfd_pkg.sv
package vfd_pkg;
  typedef struct packed {
    logic vfall;
    logic fsync;
    logic fld_rise;
    logic fld_inv;
  } vfd_cfg_t;

  localparam int VFD_SYNC_STAGES = 2;
endpackage

// File: rtl/vfd_sync.sv
module vfd_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else             stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/vfd_edge.sv
module vfd_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic rise,
  output logic fall
);
  logic lvl_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= 1'b0;
    else        lvl_d <= lvl;
  end

  assign rise = lvl & ~lvl_d;
  assign fall = ~lvl & lvl_d;
endmodule

// File: rtl/vfd_field.sv
module vfd_field (
  input  logic clk,
  input  logic rst_n,
  input  logic rise,
  input  logic fall,
  input  logic href_s,
  input  logic sel_rise,
  input  logic invert,
  output logic field
);
  logic take;

  assign take = sel_rise ? rise : fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    field <= 1'b0;
    else if (take) field <= href_s ^ invert;
  end
endmodule

// File: rtl/vfd_top.sv
module vfd_top
  import vfd_pkg::*;
#(
  parameter int SYNC_STAGES = VFD_SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vref_in,
  input  logic href_in,
  input  logic cfg_vfall,
  input  logic cfg_fsync,
  input  logic cfg_fld_rise,
  input  logic cfg_fld_inv,
  output logic vpulse,
  output logic field_id
);
  localparam int NLINES = 2;

  vfd_cfg_t          cfg;
  logic [NLINES-1:0] raw, synced;
  logic              vref_s, href_s;
  logic              v_rise, v_fall, v_mark;

  assign cfg = '{vfall: cfg_vfall, fsync: cfg_fsync,
                 fld_rise: cfg_fld_rise, fld_inv: cfg_fld_inv};
  assign raw = {href_in, vref_in};

  vfd_sync #(.WIDTH(NLINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced)
  );

  assign vref_s = synced[0];
  assign href_s = synced[1];

  vfd_edge u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(vref_s), .rise(v_rise), .fall(v_fall)
  );

  always_comb begin
    if (cfg.fsync)      v_mark = v_rise | v_fall;
    else if (cfg.vfall) v_mark = v_fall;
    else                v_mark = v_rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vpulse <= 1'b0;
    else        vpulse <= v_mark;
  end

  vfd_field u_field (
    .clk(clk), .rst_n(rst_n), .rise(v_rise), .fall(v_fall),
    .href_s(href_s), .sel_rise(cfg.fld_rise), .invert(cfg.fld_inv),
    .field(field_id)
  );
endmodule

// File: rtl/vfd_checker.sv
module vfd_checker (
  input logic clk,
  input logic rst_n,
  input logic vs,
  input logic hs,
  input logic vfall,
  input logic fsync,
  input logic fld_rise,
  input logic fld_inv,
  input logic vpulse,
  input logic field_id
);
  logic [1:0] age;
  logic       ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign ready = (age == 2'd3);

  AST_PULSE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && vpulse) |-> ($past(vs) != $past(vs, 2))); // R2

  AST_GATE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && vpulse && !$past(fsync)) |-> ($past(vs) == !$past(vfall))); // R3

  AST_FSYNC_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(fsync) && ($past(vs) != $past(vs, 2))) |-> vpulse); // R4

  AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ($past(vs) == $past(vs, 2))) |-> $stable(field_id)); // R8

  AST_FIELD_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && ($past(vs) != $past(vs, 2)) && ($past(vs) == $past(fld_rise)))
      |-> (field_id == ($past(hs) ^ $past(fld_inv)))); // R5
endmodule

bind vfd_top vfd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .vs(vref_s), .hs(href_s),
  .vfall(cfg_vfall), .fsync(cfg_fsync), .fld_rise(cfg_fld_rise),
  .fld_inv(cfg_fld_inv), .vpulse(vpulse), .field_id(field_id)
);

// File: tb/tb_vfd_top.sv
module tb_vfd_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vref_in = 1'b0, href_in = 1'b0;
  logic cfg_vfall = 1'b0, cfg_fsync = 1'b0, cfg_fld_rise = 1'b0, cfg_fld_inv = 1'b0;
  logic vpulse, field_id;
  int   n_chk = 0, n_bad = 0;
  logic exp_fld = 1'b0;

  always #10 clk = ~clk;

  vfd_top dut (
    .clk(clk), .rst_n(rst_n), .vref_in(vref_in), .href_in(href_in),
    .cfg_vfall(cfg_vfall), .cfg_fsync(cfg_fsync), .cfg_fld_rise(cfg_fld_rise),
    .cfg_fld_inv(cfg_fld_inv), .vpulse(vpulse), .field_id(field_id)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic watch(input string req, input logic exp_p);
    for (int i = 1; i <= 5; i++) begin
      @(negedge clk);
      if (i == 3) begin
        chk(req, "vpulse", vpulse, exp_p);
        chk(req, "field_id", field_id, exp_fld);
      end else begin
        chk(req, "vpulse", vpulse, 1'b0);
      end
    end
    chk(req, "field_id settled", field_id, exp_fld);
  endtask

  task automatic set_href(input string req, input logic v);
    @(negedge clk);
    href_in = v;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(req, "field_id hold on href change", field_id, exp_fld);
      chk(req, "no pulse on href change", vpulse, 1'b0);
    end
  endtask

  task automatic vref_to(input string req, input logic v, input logic exp_p, input logic new_fld);
    @(negedge clk);
    vref_in = v;
    exp_fld = new_fld;
    watch(req, exp_p);
  endtask

  task automatic t_reset;
    chk("R1", "vpulse in reset", vpulse, 1'b0);
    chk("R1", "field_id in reset", field_id, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "vpulse after reset", vpulse, 1'b0);
    chk("R1", "field_id after reset", field_id, 1'b0);
  endtask

  task automatic t_gate_rise;
    set_href("R8", 1'b1);
    vref_to("R2", 1'b1, 1'b1, exp_fld);
    vref_to("R2 R5", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_gate_fall;
    @(negedge clk); cfg_vfall = 1'b1;
    vref_to("R3", 1'b1, 1'b0, exp_fld);
    set_href("R8", 1'b0);
    vref_to("R3 R5", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_fsync;
    @(negedge clk); cfg_fsync = 1'b1; cfg_vfall = 1'b0;
    vref_to("R4 rise", 1'b1, 1'b1, exp_fld);
    set_href("R8", 1'b1);
    vref_to("R4 fall", 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_field_rise;
    @(negedge clk); cfg_fsync = 1'b0; cfg_fld_rise = 1'b1;
    set_href("R8", 1'b0);
    vref_to("R6 R10", 1'b1, 1'b1, 1'b0);
    set_href("R8", 1'b1);
    vref_to("R6 fall ignored", 1'b0, 1'b0, exp_fld);
    vref_to("R10", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_invert;
    @(negedge clk); cfg_fld_inv = 1'b1; cfg_fld_rise = 1'b0; cfg_vfall = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8", "field_id hold on invert change", field_id, exp_fld);
    end
    vref_to("R7", 1'b0, 1'b1, 1'b0);
    set_href("R8", 1'b0);
    @(negedge clk); cfg_fld_rise = 1'b1; cfg_vfall = 1'b0;
    vref_to("R7 R10", 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_cfg_change;
    @(negedge clk); cfg_vfall = 1'b1;
    watch("R9 vfall", 1'b0);
    @(negedge clk); cfg_fsync = 1'b1;
    watch("R9 fsync", 1'b0);
    @(negedge clk); cfg_fld_rise = 1'b0;
    watch("R9 fld_rise", 1'b0);
    @(negedge clk); cfg_fld_inv = 1'b0;
    watch("R9 fld_inv", 1'b0);
    vref_to("R9 new cfg", 1'b0, 1'b1, 1'b0);
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_gate_rise();
    t_gate_fall();
    t_fsync();
    t_field_rise();
    t_invert();
    t_cfg_change();
    repeat (3) @(negedge clk);
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule